// File: doc/BRIEF.md
# Parity-Checked Reversible-Gate ALU

This block is a WIDTH-bit arithmetic logic unit whose every bit slice is a network of three-line reversible gates. Each gate keeps the parity of its outputs equal to the parity of its inputs. Two gate kinds are used. The first is a duplicator, which maps (c, x, y) to (c, c^x, c^y). The second is a controlled swap. Whenever a signal has to reach two places, a duplicator copies it; no wire ever fans out directly. Constant 0 and 1 lines feed the spare gate inputs. Unused gate outputs leave the slice as garbage lines.

One full adder inside each slice serves two operations. Its carry input is gated to 0 for the exclusive-OR operation, so the same sum line gives either a^b or a^b^carry. A 4:1 selector made of three controlled-swap gates picks the slice result. Slices chain their carries, so ADD becomes a ripple-carry adder.

Each gate reports whether its own input parity differs from its output parity. The XOR of these terms across the whole array is the fault flag. A test input can invert any single gate-output line, and the flag then rises. The result, the carry out, the garbage lines and the flag are all registered together on the clock.

Top module: `rpalu`

## Requirements
- R1: The 2-bit `op` selects the operation: 2'b00 AND, 2'b01 OR, 2'b10 XOR, 2'b11 ADD.
- R2: With op 2'b00, `y` equals a & b and `cin` has no effect.
- R3: With op 2'b01, `y` equals a | b and `cin` has no effect.
- R4: With op 2'b10, `y` equals a ^ b and `cin` has no effect; the shared adder sees a carry-in of 0.
- R5: With op 2'b11, {cout, y} equals a + b + cin. The carry ripples from bit 0 upward, and `cout` is the carry out of the top bit.
- R6: For every op other than 2'b11, `cout` is 0.
- R7: `y`, `cout`, `fault` and `garbage` change only on a rising clock edge, one cycle after their inputs. A synchronous `rst` clears `y`, `cout` and `fault` to 0.
- R8: While `inj_en` is 0, `fault` is 0 for all operands and ops.
- R9: When `inj_en` is 1 and `inj_line` is below WIDTH*54, exactly one gate-output line is inverted: line slice*54 + 3*gate + pin. `fault` is 1 on the next cycle.
- R10: When `inj_en` is 1 and `inj_line` is WIDTH*54 or above, no line is inverted. `fault` stays 0 and `y` and `cout` are fault-free.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| op | input | 2 | Operation select |
| a | input | WIDTH | Operand A |
| b | input | WIDTH | Operand B |
| cin | input | 1 | Carry into bit 0 (used by ADD only) |
| inj_en | input | 1 | Test: enable single-line inversion |
| inj_line | input | $clog2(WIDTH*54+1) | Test: index of the line to invert |
| y | output | WIDTH | Registered result |
| cout | output | 1 | Registered carry out of the top slice |
| fault | output | 1 | Registered parity mismatch flag |
| garbage | output | WIDTH*24 | Registered unused gate outputs of all slices |

## Verification
The clocked checks run on every cycle. They cover the following:
- the ADD sum against integer addition;
- `cout` staying 0 outside ADD;
- the flag staying low without injection;
- the flag rising after any in-range injection.

Each slice also checks its AND, OR and XOR outputs combinationally whenever none of its lines is inverted.

Some behaviours show only in the bench's scenarios:
- the one-cycle latency and the reset clearing;
- immunity to `cin` in the logic ops;
- the sweep that inverts each of the 216 lines in turn;
- out-of-range injection codes leaving the result intact.

// File: rtl/rpalu_pkg.sv
package rpalu_pkg;

   // gate kinds
   localparam int GK_DUP   = 0;   // (c,x,y) -> (c, c^x, c^y)
   localparam int GK_CSWAP = 1;   // (c,x,y) -> (c, c?y:x, c?x:y)

   // gates and lines of one bit slice
   localparam int SLICE_GATES   = 18;
   localparam int SLICE_LINES   = SLICE_GATES * 3;
   localparam int SLICE_GARBAGE = 24;

   // operation encoding
   localparam logic [1:0] OP_AND = 2'b00;
   localparam logic [1:0] OP_OR  = 2'b01;
   localparam logic [1:0] OP_XOR = 2'b10;
   localparam logic [1:0] OP_ADD = 2'b11;

endpackage

// File: rtl/rpalu_gate.sv
module rpalu_gate
   import rpalu_pkg::*;
#(
   parameter int KIND = GK_DUP
) (
   input  logic [2:0] in,     // in[0] is the control line
   input  logic [2:0] flip,   // test inversion of each output
   output logic [2:0] out,
   output logic       perr    // input parity differs from output parity
);

   logic [2:0] raw;

   generate
      if (KIND == GK_DUP) begin : g_dup
         assign raw = {in[0] ^ in[2], in[0] ^ in[1], in[0]};
      end else if (KIND == GK_CSWAP) begin : g_cswap
         assign raw = in[0] ? {in[1], in[2], in[0]} : in;
      end else begin : g_bad
         $error("rpalu_gate: unknown KIND %0d", KIND);
         assign raw = in;
      end
   endgenerate

   assign out  = raw ^ flip;
   assign perr = (^in) ^ (^out);

endmodule

// File: rtl/rpalu_slice.sv
module rpalu_slice
   import rpalu_pkg::*;
(
   input  logic [1:0]               op,
   input  logic                     a,
   input  logic                     b,
   input  logic                     cin,
   input  logic [SLICE_LINES-1:0]   flip,
   output logic                     res,
   output logic                     cout,
   output logic [SLICE_GARBAGE-1:0] garb,
   output logic                     perr
);

   logic [2:0]             g [SLICE_GATES];
   logic [SLICE_GATES-1:0] pe;

   // copies of the operands and select bits
   rpalu_gate #(.KIND(GK_DUP))   u_g0  (.in({1'b0, 1'b0, a}),            .flip(flip[0*3 +: 3]),  .out(g[0]),  .perr(pe[0]));
   rpalu_gate #(.KIND(GK_DUP))   u_g1  (.in({1'b0, 1'b0, b}),            .flip(flip[1*3 +: 3]),  .out(g[1]),  .perr(pe[1]));
   rpalu_gate #(.KIND(GK_DUP))   u_g2  (.in({1'b0, 1'b0, op[0]}),        .flip(flip[2*3 +: 3]),  .out(g[2]),  .perr(pe[2]));
   rpalu_gate #(.KIND(GK_DUP))   u_g3  (.in({1'b0, 1'b0, g[2][0]}),      .flip(flip[3*3 +: 3]),  .out(g[3]),  .perr(pe[3]));
   rpalu_gate #(.KIND(GK_DUP))   u_g4  (.in({1'b0, 1'b0, op[1]}),        .flip(flip[4*3 +: 3]),  .out(g[4]),  .perr(pe[4]));

   // carry-in gated by op[0]: zero for XOR, passed for ADD
   rpalu_gate #(.KIND(GK_CSWAP)) u_g5  (.in({cin, 1'b0, g[2][1]}),       .flip(flip[5*3 +: 3]),  .out(g[5]),  .perr(pe[5]));

   // logic functions: g6[2] = a&b, g7[2] = a|b
   rpalu_gate #(.KIND(GK_CSWAP)) u_g6  (.in({1'b0, g[1][1], g[0][1]}),   .flip(flip[6*3 +: 3]),  .out(g[6]),  .perr(pe[6]));
   rpalu_gate #(.KIND(GK_CSWAP)) u_g7  (.in({g[1][2], 1'b1, g[0][2]}),   .flip(flip[7*3 +: 3]),  .out(g[7]),  .perr(pe[7]));

   // shared full adder
   rpalu_gate #(.KIND(GK_DUP))   u_g8  (.in({1'b0, g[1][0], g[0][0]}),   .flip(flip[8*3 +: 3]),  .out(g[8]),  .perr(pe[8]));
   rpalu_gate #(.KIND(GK_DUP))   u_g9  (.in({1'b0, 1'b0, g[5][1]}),      .flip(flip[9*3 +: 3]),  .out(g[9]),  .perr(pe[9]));
   rpalu_gate #(.KIND(GK_DUP))   u_g10 (.in({1'b0, g[9][1], g[8][1]}),   .flip(flip[10*3 +: 3]), .out(g[10]), .perr(pe[10]));
   rpalu_gate #(.KIND(GK_CSWAP)) u_g11 (.in({g[9][2], g[8][0], g[10][2]}), .flip(flip[11*3 +: 3]), .out(g[11]), .perr(pe[11]));
   rpalu_gate #(.KIND(GK_DUP))   u_g12 (.in({1'b0, 1'b0, g[10][1]}),     .flip(flip[12*3 +: 3]), .out(g[12]), .perr(pe[12]));

   // 4:1 selector from three controlled swaps
   rpalu_gate #(.KIND(GK_CSWAP)) u_g13 (.in({g[7][2], g[6][2], g[2][2]}),   .flip(flip[13*3 +: 3]), .out(g[13]), .perr(pe[13]));
   rpalu_gate #(.KIND(GK_CSWAP)) u_g14 (.in({g[12][2], g[12][1], g[3][0]}), .flip(flip[14*3 +: 3]), .out(g[14]), .perr(pe[14]));
   rpalu_gate #(.KIND(GK_CSWAP)) u_g15 (.in({g[14][1], g[13][1], g[4][0]}), .flip(flip[15*3 +: 3]), .out(g[15]), .perr(pe[15]));

   // carry out only for ADD
   rpalu_gate #(.KIND(GK_CSWAP)) u_g16 (.in({g[11][1], 1'b0, g[3][1]}),  .flip(flip[16*3 +: 3]), .out(g[16]), .perr(pe[16]));
   rpalu_gate #(.KIND(GK_CSWAP)) u_g17 (.in({g[16][1], 1'b0, g[4][1]}),  .flip(flip[17*3 +: 3]), .out(g[17]), .perr(pe[17]));

   assign res  = g[15][1];
   assign cout = g[17][1];
   assign perr = ^pe;

   assign garb = {g[3][2],  g[4][2],  g[5][0],  g[5][2],  g[6][1:0], g[7][1:0],
                  g[8][2],  g[9][0],  g[10][0], g[11][0], g[11][2],  g[12][0],
                  g[13][0], g[13][2], g[14][0], g[14][2], g[15][0],  g[15][2],
                  g[16][0], g[16][2], g[17][0], g[17][2]};

   // functional checks while this slice is fault-free
   always_comb begin
      if (flip == '0) begin
         if (op == OP_AND) assert_and_R2 : assert (res == (a & b));
         if (op == OP_OR)  assert_or_R3  : assert (res == (a | b));
         if (op == OP_XOR) assert_xor_R4 : assert (res == (a ^ b));
      end
   end

endmodule

// File: rtl/rpalu.sv
module rpalu
   import rpalu_pkg::*;
#(
   parameter  int WIDTH = 4,
   localparam int NLINE = WIDTH * SLICE_LINES,
   localparam int IDX_W = $clog2(NLINE + 1),
   localparam int NGARB = WIDTH * SLICE_GARBAGE
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [1:0]       op,
   input  logic [WIDTH-1:0] a,
   input  logic [WIDTH-1:0] b,
   input  logic             cin,
   input  logic             inj_en,
   input  logic [IDX_W-1:0] inj_line,
   output logic [WIDTH-1:0] y,
   output logic             cout,
   output logic             fault,
   output logic [NGARB-1:0] garbage
);

   generate
      if (WIDTH < 1) begin : g_chk_w
         $error("rpalu: WIDTH must be at least 1");
      end
   endgenerate

   logic [NLINE-1:0] mask;
   logic [WIDTH:0]   carry;
   logic [WIDTH-1:0] res_d;
   logic [WIDTH-1:0] perr;
   logic [NGARB-1:0] garb_d;

   // one-hot inversion mask; codes at or beyond NLINE invert nothing
   for (genvar k = 0; k < NLINE; k++) begin : g_mask
      assign mask[k] = inj_en && (inj_line == IDX_W'(k));
   end

   assign carry[0] = cin;

   for (genvar i = 0; i < WIDTH; i++) begin : g_slice
      rpalu_slice u_slice (
         .op   (op),
         .a    (a[i]),
         .b    (b[i]),
         .cin  (carry[i]),
         .flip (mask[i*SLICE_LINES +: SLICE_LINES]),
         .res  (res_d[i]),
         .cout (carry[i+1]),
         .garb (garb_d[i*SLICE_GARBAGE +: SLICE_GARBAGE]),
         .perr (perr[i])
      );
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         y       <= '0;
         cout    <= 1'b0;
         fault   <= 1'b0;
         garbage <= '0;
      end else begin
         y       <= res_d;
         cout    <= carry[WIDTH];
         fault   <= ^perr;
         garbage <= garb_d;
      end
   end

   assert_sum_R5 : assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && !$past(inj_en) && $past(op) == OP_ADD) |->
      ({cout, y} == $past({1'b0, a} + {1'b0, b} + {{WIDTH{1'b0}}, cin})));

   assert_cout_quiet_R6 : assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && !$past(inj_en) && $past(op) != OP_ADD) |-> !cout);

   assert_clean_R8 : assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && !$past(inj_en)) |-> !fault);

   assert_detect_R9 : assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && $past(inj_en) && ($past(inj_line) < IDX_W'(NLINE))) |-> fault);

endmodule

// File: tb/sim_rpalu.sv
`timescale 1ns/1ps
module sim_rpalu;

   localparam int W     = 4;
   localparam int NLINE = W * 54;
   localparam int IDX_W = $clog2(NLINE + 1);

   logic             clk = 1'b0;
   logic             rst = 1'b1;
   logic [1:0]       op = '0;
   logic [W-1:0]     a = '0, b = '0;
   logic             cin = 1'b0;
   logic             inj_en = 1'b0;
   logic [IDX_W-1:0] inj_line = '0;
   logic [W-1:0]     y;
   logic             cout, fault;
   logic [W*24-1:0]  garbage;

   int checks = 0, errors = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   rpalu #(.WIDTH(W)) u0 (
      .clk(clk), .rst(rst), .op(op), .a(a), .b(b), .cin(cin),
      .inj_en(inj_en), .inj_line(inj_line),
      .y(y), .cout(cout), .fault(fault), .garbage(garbage)
   );

   // {op, a, b, cin, y, cout}
   localparam logic [15:0] VEC [12] = '{
      16'b00_1100_1010_1_1000_0,
      16'b01_1100_1010_0_1110_0,
      16'b10_1100_1010_1_0110_0,
      16'b11_0111_0001_0_1000_0,
      16'b11_1111_0001_0_0000_1,
      16'b11_1111_1111_1_1111_1,
      16'b11_0000_0000_1_0001_0,
      16'b10_1111_1111_0_0000_0,
      16'b01_0000_0000_1_0000_0,
      16'b00_1111_1111_0_1111_0,
      16'b11_1001_0110_1_0000_1,
      16'b10_0101_0011_0_0110_0
   };

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic logic [W:0] model(input logic [1:0] o, input logic [W-1:0] x,
                                        input logic [W-1:0] z, input logic ci);
      case (o)
         2'b00:   return {1'b0, x & z};
         2'b01:   return {1'b0, x | z};
         2'b10:   return {1'b0, x ^ z};
         default: return {1'b0, x} + {1'b0, z} + {{W{1'b0}}, ci};
      endcase
   endfunction

   function automatic string tag(input logic [1:0] o);
      case (o)
         2'b00:   return "R2 AND";
         2'b01:   return "R3 OR";
         2'b10:   return "R4 XOR";
         default: return "R5 ADD";
      endcase
   endfunction

   // drive at a falling edge, let one rising edge pass, sample at the next falling edge
   task automatic apply(input logic [1:0] o, input logic [W-1:0] x, input logic [W-1:0] z,
                        input logic ci, input logic ie, input logic [IDX_W-1:0] il);
      @(negedge clk);
      op = o; a = x; b = z; cin = ci; inj_en = ie; inj_line = il;
      @(negedge clk);
   endtask

   task automatic summary;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog expired");
         summary();
         $finish;
      end
   end

   initial begin
      logic [W:0] e;
      // R7: reset state
      apply(2'b11, 4'hF, 4'hF, 1'b1, 1'b0, '0);
      check("R7 reset y", 32'(y), 0);
      check("R7 reset cout", 32'(cout), 0);
      check("R7 reset fault", 32'(fault), 0);
      rst = 1'b0;

      // R1: table of encodings and corner operands
      for (int i = 0; i < 12; i++) begin
         apply(VEC[i][15:14], VEC[i][13:10], VEC[i][9:6], VEC[i][5], 1'b0, '0);
         check({"R1 ", tag(VEC[i][15:14]), " y"}, 32'(y), 32'(VEC[i][4:1]));
         check({"R6 ", tag(VEC[i][15:14]), " cout"}, 32'(cout), 32'(VEC[i][0]));
      end

      // exhaustive sweep of all ops, operands and carry-in
      for (int o = 0; o < 4; o++)
         for (int x = 0; x < 16; x++)
            for (int z = 0; z < 16; z++)
               for (int ci = 0; ci < 2; ci++) begin
                  apply(2'(o), 4'(x), 4'(z), 1'(ci), 1'b0, '0);
                  e = model(2'(o), 4'(x), 4'(z), 1'(ci));
                  check({tag(2'(o)), " R6 sweep"}, 32'({cout, y}), 32'(e));
                  check("R8 no-injection flag", 32'(fault), 0);
               end

      // R7: latency of one edge
      apply(2'b00, 4'hF, 4'hF, 1'b0, 1'b0, '0);
      @(negedge clk);
      op = 2'b00; a = 4'h0; b = 4'h0;
      #1 check("R7 hold before edge", 32'(y), 32'hF);
      @(negedge clk);
      check("R7 update after edge", 32'(y), 0);

      // R9: every single line inverted raises the flag
      for (int l = 0; l < NLINE; l++) begin
         apply(2'(l % 4), 4'(l * 7), 4'(l * 3 + 5), 1'(l % 3 == 0), 1'b1, IDX_W'(l));
         check("R9 injected line flagged", 32'(fault), 1);
      end
      apply(2'b11, 4'h5, 4'hA, 1'b1, 1'b0, '0);
      check("R8 flag clears after injection", 32'(fault), 0);

      // R10: out-of-range codes do nothing
      apply(2'b11, 4'h9, 4'h8, 1'b1, 1'b1, IDX_W'(NLINE));
      check("R10 first unused code flag", 32'(fault), 0);
      check("R10 first unused code sum", 32'({cout, y}), 32'h12);
      apply(2'b01, 4'h3, 4'h4, 1'b0, 1'b1, '1);
      check("R10 top code flag", 32'(fault), 0);
      check("R10 top code result", 32'({cout, y}), 32'h07);

      // R7: synchronous reset mid-run
      apply(2'b11, 4'hF, 4'h1, 1'b0, 1'b1, '0);
      @(negedge clk);
      rst = 1'b1;
      @(negedge clk);
      check("R7 reset clears y", 32'(y), 0);
      check("R7 reset clears cout", 32'(cout), 0);
      check("R7 reset clears fault", 32'(fault), 0);
      rst = 1'b0;
      inj_en = 1'b0;

      done = 1'b1;
      summary();
      $finish;
   end

endmodule